// File: doc/BRIEF.md
# Dual-Quantizer Noise-Cancellation Recombiner

This block is the digital back end of a second-order sigma-delta modulator built around two quantizers. Every sample it receives a three-level code from the coarse quantizer inside the feedback loop and a 4-bit code from the fine quantizer that watches the loop from outside. The coarse path is delayed by one sample. The block then estimates the coarse quantizer's error as the fine code minus the aligned coarse value. That estimate passes through a second-order cancellation filter, g·(1 − b1·z⁻¹)(1 − b2·z⁻¹), and the filtered error is added back to the aligned coarse value. The result is one saturated output word per input sample.

The two pole terms b1 and b2 and the gain term g are signed fixed-point values. g is the precomputed reciprocal of the product of the two integrator gains. All three are held in registers and can be reloaded while samples are flowing, so an off-chip or firmware estimator can refine them without stopping the stream. With all three at unity the filter becomes the ideal (1 − z⁻¹)² shape.

A small fill controller has three states: `FILL0`, `FILL1` and `LIVE`. It steps `FILL0 → FILL1` on the first valid sample and `FILL1 → LIVE` on the second. It stays in `LIVE` until reset, and reset returns it to `FILL0`. The output is forced to zero while the filter history is incomplete.

Top module: `dq_noise_cancel`

## Requirements
- R1: A synchronous reset sets `out_vld` to 0 and `out_data` to 0. It clears the one-sample coarse delay and both error-history registers, returns the fill controller to `FILL0`, and sets b1, b2 and g to unity (2^14 with 14 fraction bits).
- R2: The coarse code is two's complement on 2 bits: `2'b11` = −1, `2'b00` = 0 and `2'b01` = +1. The unused code `2'b10` counts as 0. The coarse weight is LO_STEP = 16 half-LSB units of the fine quantizer, which already includes the ×2 correction for the half-gain second integrator. The fine code is offset binary 0..15 and is mapped to 2·code − 15 half-LSB units.
- R3: `out_vld` is `in_vld` delayed by exactly one clock. `out_data` changes only in the clock after a valid sample and holds its value otherwise.
- R4: The outputs for the first two valid samples after reset are 0, whatever the inputs. The third valid sample is the first to give a filtered result.
- R5: With unity coefficients, for sample n: c[n] is the coarse weight of sample n and e[n] = f[n] − c[n−1], where f is the mapped fine value. The output is y[n] = c[n−1] + e[n] − 2·e[n−1] + e[n−2].
- R6: With general coefficients (signed, 2 integer bits and 14 fraction bits), the output is y[n] = c[n−1] + floor(g·(e[n]·2^28 − (b1+b2)·e[n−1]·2^14 + b1·b2·e[n−2]) / 2^42).
- R7: A coefficient load (`coef_ld` high for one clock) takes effect for samples presented in later clocks. A sample presented in the same clock as the load still uses the old coefficients. A load does not disturb the coarse delay or the error history.
- R8: The output saturates to the signed range of `OUT_W` bits, −512..511 by default, and never wraps.
- R9: Clocks with `in_vld` low do not advance the coarse delay, the error history or the fill controller. A stream with idle gaps gives the same output values as the same stream without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | A sample pair is present this clock |
| lo_code | input | 2 | Three-level coarse code, two's complement |
| hi_code | input | HI_W | Fine quantizer code, offset binary |
| coef_ld | input | 1 | Load the three coefficient inputs |
| coef_b1 | input | COEF_W | First pole term, signed, 14 fraction bits |
| coef_b2 | input | COEF_W | Second pole term, signed, 14 fraction bits |
| coef_g | input | COEF_W | Reciprocal gain term, signed, 14 fraction bits |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| out_data | output | OUT_W | Recombined output, signed, half-LSB units |

## Verification
The bench targets the fill boundary. A design that counts wrongly would emit nonzero data on the second sample, or hold zero into the third. It also covers the unused coarse code and the offset-binary fine code; a decode slip shows up as a constant bias or a sign flip. Loads are placed both in idle clocks and in the same clock as a valid sample. A design that applies new coefficients one sample early, or clears the history on a load, would diverge from the scoreboard at once. Extreme coefficients drive the sum past both rails, which exposes a wrapping adder as a large jump of the wrong sign. Idle gaps inside the stream catch a delay line that shifts on every clock instead of every sample.

// File: rtl/dq_pkg.sv
package dq_pkg;

    typedef enum logic [1:0] {
        FILL0 = 2'd0,
        FILL1 = 2'd1,
        LIVE  = 2'd2
    } fill_state_t;

    // three-level code to level: 01 -> +1, 11 -> -1, 00/10 -> 0
    function automatic logic signed [1:0] lo_level(input logic [1:0] code);
        logic signed [1:0] lvl;
        unique case (code)
            2'b01:   lvl = 2'sb01;
            2'b11:   lvl = 2'sb11;
            default: lvl = 2'sb00;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/dq_fill_ctrl.sv
module dq_fill_ctrl
    import dq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic live
);

    fill_state_t state_q;
    fill_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL0:   if (adv) state_d = FILL1;
            FILL1:   if (adv) state_d = LIVE;
            LIVE:    state_d = LIVE;
            default: state_d = FILL0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FILL0;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LIVE:    live = 1'b1;
            default: live = 1'b0;
        endcase
    end

    assert_live_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == LIVE) |=> (state_q == LIVE));

    assert_fill_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!adv && state_q != LIVE) |=> $stable(state_q));

endmodule

// File: rtl/dq_input_align.sv
module dq_input_align
    import dq_pkg::*;
#(
    parameter int HI_W    = 4,
    parameter int LO_STEP = 16,
    parameter int ERR_W   = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  logic [1:0]              lo_code,
    input  logic [HI_W-1:0]         hi_code,
    output logic signed [ERR_W-1:0] err,
    output logic signed [ERR_W-1:0] lo_aligned
);

    localparam logic signed [ERR_W-1:0] LO_POS = ERR_W'(LO_STEP);
    localparam logic signed [ERR_W-1:0] HI_OFF = ERR_W'((2 ** HI_W) - 1);

    logic signed [ERR_W-1:0] lo_now;
    logic signed [ERR_W-1:0] hi_now;
    logic signed [ERR_W-1:0] lo_dly_q;

    always_comb begin
        unique case (lo_level(lo_code))
            2'sb01:  lo_now = LO_POS;
            2'sb11:  lo_now = -LO_POS;
            default: lo_now = '0;
        endcase
    end

    // offset binary -> odd-symmetric half-LSB value
    assign hi_now = signed'(ERR_W'({hi_code, 1'b0})) - HI_OFF;

    // coarse path one-sample delay
    always_ff @(posedge clk) begin
        if (rst)      lo_dly_q <= '0;
        else if (adv) lo_dly_q <= lo_now;
    end

    assign err        = hi_now - lo_dly_q;
    assign lo_aligned = lo_dly_q;

    assert_h1_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(lo_dly_q));

    assert_h1_follow_R5: assert property (@(posedge clk) disable iff (rst)
        adv |=> (lo_dly_q == $past(lo_now)));

endmodule

// File: rtl/dq_cancel_fir.sv
module dq_cancel_fir #(
    parameter int ERR_W  = 7,
    parameter int COEF_W = 16,
    parameter int FRAC   = 14,
    parameter int PROD_W = 58
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      adv,
    input  logic signed [ERR_W-1:0]   err,
    input  logic                      coef_ld,
    input  logic signed [COEF_W-1:0]  coef_b1,
    input  logic signed [COEF_W-1:0]  coef_b2,
    input  logic signed [COEF_W-1:0]  coef_g,
    output logic signed [PROD_W-1:0]  filt
);

    localparam int ACC_W = 2 * COEF_W + ERR_W + 3;
    localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << FRAC);

    logic signed [COEF_W-1:0] b1_q, b2_q, g_q;
    logic signed [ERR_W-1:0]  hist_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            b1_q <= UNITY;
            b2_q <= UNITY;
            g_q  <= UNITY;
        end else if (coef_ld) begin
            b1_q <= coef_b1;
            b2_q <= coef_b2;
            g_q  <= coef_g;
        end
    end

    // error history, advanced once per valid sample
    generate
        for (genvar k = 0; k < 2; k++) begin : g_hist
            always_ff @(posedge clk) begin
                if (rst)      hist_q[k] <= '0;
                else if (adv) hist_q[k] <= (k == 0) ? err : hist_q[k-1 < 0 ? 0 : k-1];
            end
        end
    endgenerate

    logic signed [ACC_W-1:0]  x0, x1, x2, c1, c2, acc;
    logic signed [PROD_W-1:0] acc_w, g_w, prod;

    always_comb begin
        x0    = ACC_W'(err);
        x1    = ACC_W'(hist_q[0]);
        x2    = ACC_W'(hist_q[1]);
        c1    = ACC_W'(b1_q) + ACC_W'(b2_q);
        c2    = ACC_W'(b1_q) * ACC_W'(b2_q);
        acc   = (x0 <<< (2 * FRAC)) - ((c1 * x1) <<< FRAC) + (c2 * x2);
        acc_w = PROD_W'(acc);
        g_w   = PROD_W'(g_q);
        prod  = acc_w * g_w;
        filt  = prod >>> (3 * FRAC);
    end

    assert_coef_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !coef_ld |=> ($stable(b1_q) && $stable(b2_q) && $stable(g_q)));

    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(hist_q[0]) && $stable(hist_q[1])));

    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (rst)
        adv |=> (hist_q[1] == $past(hist_q[0])));

endmodule

// File: rtl/dq_noise_cancel.sv
module dq_noise_cancel #(
    parameter int HI_W    = 4,
    parameter int LO_STEP = 16,
    parameter int COEF_W  = 16,
    parameter int FRAC    = 14,
    parameter int OUT_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic [1:0]               lo_code,
    input  logic [HI_W-1:0]          hi_code,
    input  logic                     coef_ld,
    input  logic signed [COEF_W-1:0] coef_b1,
    input  logic signed [COEF_W-1:0] coef_b2,
    input  logic signed [COEF_W-1:0] coef_g,
    output logic                     out_vld,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int LO_BITS = $clog2(LO_STEP);
    localparam int ERR_W   = ((LO_BITS > HI_W) ? LO_BITS : HI_W) + 3;
    localparam int PROD_W  = 3 * COEF_W + ERR_W + 3;
    localparam logic signed [PROD_W-1:0] Y_MAX = PROD_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] Y_MIN = -Y_MAX - PROD_W'(1);

    logic signed [ERR_W-1:0]  err;
    logic signed [ERR_W-1:0]  lo_aligned;
    logic signed [PROD_W-1:0] filt;
    logic signed [PROD_W-1:0] y_full;
    logic signed [OUT_W-1:0]  y_sat;
    logic                     live;

    dq_input_align #(
        .HI_W   (HI_W),
        .LO_STEP(LO_STEP),
        .ERR_W  (ERR_W)
    ) align_i (
        .clk       (clk),
        .rst       (rst),
        .adv       (in_vld),
        .lo_code   (lo_code),
        .hi_code   (hi_code),
        .err       (err),
        .lo_aligned(lo_aligned)
    );

    dq_cancel_fir #(
        .ERR_W (ERR_W),
        .COEF_W(COEF_W),
        .FRAC  (FRAC),
        .PROD_W(PROD_W)
    ) fir_i (
        .clk    (clk),
        .rst    (rst),
        .adv    (in_vld),
        .err    (err),
        .coef_ld(coef_ld),
        .coef_b1(coef_b1),
        .coef_b2(coef_b2),
        .coef_g (coef_g),
        .filt   (filt)
    );

    dq_fill_ctrl fill_i (
        .clk (clk),
        .rst (rst),
        .adv (in_vld),
        .live(live)
    );

    always_comb begin
        y_full = PROD_W'(lo_aligned) + filt;
        if (!live)               y_sat = '0;
        else if (y_full > Y_MAX) y_sat = Y_MAX[OUT_W-1:0];
        else if (y_full < Y_MIN) y_sat = Y_MIN[OUT_W-1:0];
        else                     y_sat = y_full[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_data <= y_sat;
        end
    end

    assert_vld_delay_R3: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_data)));

    assert_fill_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !live) |=> (out_data == '0));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (in_vld && live && y_full > Y_MAX) |=> (out_data == Y_MAX[OUT_W-1:0]));

endmodule

// File: tb/dq_noise_cancel_tb_top.sv
module dq_noise_cancel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  lo_code = 2'b00;
    logic [3:0]  hi_code = 4'd0;
    logic        coef_ld = 1'b0;
    logic signed [15:0] coef_b1 = '0, coef_b2 = '0, coef_g = '0;
    logic        out_vld;
    logic signed [9:0] out_data;

    always #5 clk = ~clk;

    dq_noise_cancel dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .lo_code(lo_code), .hi_code(hi_code),
        .coef_ld(coef_ld), .coef_b1(coef_b1), .coef_b2(coef_b2), .coef_g(coef_g),
        .out_vld(out_vld), .out_data(out_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int    exp_q[$];
    string tag_q[$];

    // reference model state
    int m_c1, m_e1, m_e2, m_cnt;
    int m_b1 = 16384, m_b2 = 16384, m_g = 16384;

    function automatic int lo_lvl(logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        m_c1 = 0; m_e1 = 0; m_e2 = 0; m_cnt = 0;
        m_b1 = 16384; m_b2 = 16384; m_g = 16384;
    endtask

    task automatic send(logic [1:0] lc, int hc, bit ld, int nb1, int nb2, int ng, string tag);
        int c, f, e, y;
        longint acc, prod;
        @(posedge clk); #1;
        in_vld = 1'b1; lo_code = lc; hi_code = 4'(hc);
        coef_ld = ld; coef_b1 = 16'(nb1); coef_b2 = 16'(nb2); coef_g = 16'(ng);
        c = lo_lvl(lc) * 16;
        f = 2 * hc - 15;
        e = f - m_c1;
        if (m_cnt < 2) y = 0;
        else begin
            acc  = (longint'(e) <<< 28) - ((longint'(m_b1 + m_b2) * m_e1) <<< 14)
                 + longint'(m_b1) * longint'(m_b2) * m_e2;
            prod = acc * m_g;
            y = m_c1 + int'(prod >>> 42);
            if (y > 511) y = 511;
            if (y < -512) y = -512;
        end
        exp_q.push_back(y); tag_q.push_back(tag);
        m_e2 = m_e1; m_e1 = e; m_c1 = c; m_cnt++;
        if (ld) begin m_b1 = nb1; m_b2 = nb2; m_g = ng; end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_vld = 1'b0; coef_ld = 1'b0;
        end
    endtask

    task automatic load_only(int nb1, int nb2, int ng);
        @(posedge clk); #1;
        in_vld = 1'b0; coef_ld = 1'b1;
        coef_b1 = 16'(nb1); coef_b2 = 16'(nb2); coef_g = 16'(ng);
        m_b1 = nb1; m_b2 = nb2; m_g = ng;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; in_vld = 1'b0; coef_ld = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
        check(out_data == 0, "R1 out_data after reset", int'(out_data), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        model_reset();
    endtask

    // monitor / scoreboard
    int last_out = 0;
    always @(negedge clk) begin
        if (rst) last_out = 0;
        else if (out_vld) begin
            if (exp_q.size() == 0)
                check(1'b0, "R3 unexpected out_vld", int'(out_data), 0);
            else begin
                int    ev;
                string tg;
                ev = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(int'(out_data) == ev, tg, int'(out_data), ev);
            end
            last_out = int'(out_data);
        end else begin
            check(int'(out_data) == last_out, "R3 hold while idle", int'(out_data), last_out);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();

        // R2 R5 R4: all coarse codes (incl. unused 10), full fine sweep, unity coefs
        for (int i = 0; i < 16; i++) begin
            logic [1:0] lc;
            lc = (i % 4 == 0) ? 2'b00 : (i % 4 == 1) ? 2'b01 : (i % 4 == 2) ? 2'b11 : 2'b10;
            send(lc, i, 1'b0, 0, 0, 0, (i < 2) ? "R4 fill zero" : "R2 R5 ideal path");
        end

        // R9: idle gaps inside the stream
        for (int i = 0; i < 10; i++) begin
            send((i % 2 == 0) ? 2'b11 : 2'b01, (i * 7) % 16, 1'b0, 0, 0, 0, "R9 gapped stream");
            idle(i % 3);
        end

        // R7 R6: load in an idle clock, then continue with general coefficients
        load_only(14746, 15565, 17236);
        for (int i = 0; i < 12; i++)
            send((i % 3 == 0) ? 2'b01 : (i % 3 == 1) ? 2'b00 : 2'b11, (i * 5 + 3) % 16,
                 1'b0, 0, 0, 0, "R6 general coefficients");

        // R7: load in the same clock as a valid sample
        send(2'b01, 12, 1'b1, -8192, 20000, 12000, "R7 same-clock load uses old");
        for (int i = 0; i < 6; i++)
            send((i % 2 == 0) ? 2'b00 : 2'b11, (i * 3) % 16, 1'b0, 0, 0, 0, "R7 new coefficients");

        // R8: drive both rails
        load_only(-32768, -32768, 32767);
        for (int i = 0; i < 6; i++) send(2'b11, 15, 1'b0, 0, 0, 0, "R8 positive saturation");
        for (int i = 0; i < 6; i++) send(2'b01, 0, 1'b0, 0, 0, 0, "R8 negative saturation");
        idle(3);

        // R1 R4: reset mid-run restores unity coefs and refills
        do_reset();
        for (int i = 0; i < 6; i++)
            send((i % 2 == 0) ? 2'b01 : 2'b11, 15 - i, 1'b0, 0, 0, 0,
                 (i < 2) ? "R4 refill zero" : "R1 unity after reset");
        idle(4);

        check(exp_q.size() == 0, "R3 all results produced", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule